// File: doc/BRIEF.md
# Hashtable Aging Bitmap

This block keeps one activity bit for every entry of an 8192-entry lookup table, held as 256 words of 32 bits. Each time the match engine hits an entry, it presents the entry number with a valid strobe, and the block sets the matching bit. A bit that reads 0 marks an entry that has not been hit since it was last cleared. A bit that reads 1 marks an entry that has been hit at least once since then.

Software reaches the bitmap through a word-addressed bus port. It reads a word to sample activity, then writes the word back, normally with zeros, to start a new aging interval. The entry number splits into a word address and a bit position. Bits [12:5] of the number select the word, and bits [4:0] select the bit within it.

The match side and the bus side run in the same cycle without stalling. When a hit and a bus write reach the same word in one cycle, the hit is ORed into the written data, so no hit is lost to a clear.

Top module: `aging_bitmap`

## Requirements
- R1: Reset clears every bit, and it sets the read data register to 0.
- R2: When `hit_valid` is high at a clock edge, the block sets bit `hit_index[4:0]` of word `hit_index[12:5]`. The new bit can be read from the following cycle on.
- R3: A hit changes no other bit. A set bit stays at 1 until a bus write replaces its word.
- R4: A bus write (`bus_req`=1, `bus_we`=1) replaces all 32 bits of word `bus_addr` with `bus_wdata`.
- R5: When a hit and a bus write reach the same word in one cycle, the stored word becomes `bus_wdata` ORed with the hit bit.
- R6: When a hit and a bus write reach different words in one cycle, both take full effect.
- R7: A bus read (`bus_req`=1, `bus_we`=0) loads `bus_rdata` at the clock edge where the address is presented. The data is valid in the next cycle. `bus_rdata` holds its value until the next read.
- R8: While `hit_valid` is low, `hit_index` has no effect on the bitmap.
- R9: A read and a hit to the same word in the same cycle return the word as it was before the hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Match engine hit strobe |
| hit_index | input | 13 | Number of the entry that was hit |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The bench aims hits and bus writes at the same word in the same cycle. A design that gave the write priority would lose the hit bit, so a later read would show a 0 where the hit should have left a 1.

It also reads a word in the same cycle as a hit to it. A read path that bypassed the stored value would return the new bit one cycle early.

Random traffic confined to a few words checks three more things:
- set bits stay set;
- hits leave neighbouring bits alone, which catches a wrong index split;
- `bus_rdata` holds between reads, which catches a read port that reloads on every cycle.

// File: rtl/aging_pkg.sv
package aging_pkg;
    localparam int unsigned AGE_ENTRIES = 8192;
    localparam int unsigned AGE_WORD_W  = 32;
    localparam int unsigned AGE_WORDS   = AGE_ENTRIES / AGE_WORD_W;
    localparam int unsigned AGE_IDX_W   = $clog2(AGE_ENTRIES);
    localparam int unsigned AGE_ADDR_W  = $clog2(AGE_WORDS);
    localparam int unsigned AGE_BIT_W   = $clog2(AGE_WORD_W);
endpackage

// File: rtl/aging_index_decode.sv
module aging_index_decode #(
    parameter int unsigned IDX_W  = 13,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned BIT_W  = $clog2(WORD_W),
    localparam int unsigned ADDR_W = IDX_W - BIT_W
) (
    input  logic              valid,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] word_sel,
    output logic [WORD_W-1:0] bit_mask
);
    always_comb begin
        word_sel = index[IDX_W-1:BIT_W];
        bit_mask = '0;
        if (valid) begin
            bit_mask[index[BIT_W-1:0]] = 1'b1;
        end
    end
endmodule

// File: rtl/aging_word_cell.sv
module aging_word_cell #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_mask,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] q_next;

    always_comb begin
        if (wr_en) begin
            q_next = wr_data | set_mask;
        end else begin
            q_next = q | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/aging_read_port.sv
module aging_read_port #(
    parameter int unsigned NUM_WORDS = 256,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned ADDR_W   = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
    output logic [WORD_W-1:0]                 rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= words[addr];
        end
    end
endmodule

// File: rtl/aging_bitmap.sv
module aging_bitmap
    import aging_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hit_valid,
    input  logic [AGE_IDX_W-1:0]  hit_index,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [AGE_ADDR_W-1:0] bus_addr,
    input  logic [AGE_WORD_W-1:0] bus_wdata,
    output logic [AGE_WORD_W-1:0] bus_rdata
);
    logic [AGE_ADDR_W-1:0]                hit_word;
    logic [AGE_WORD_W-1:0]                hit_mask;
    logic [AGE_WORDS-1:0][AGE_WORD_W-1:0] words;
    logic                                 wr_strobe;
    logic                                 rd_strobe;

    assign wr_strobe = bus_req & bus_we;
    assign rd_strobe = bus_req & ~bus_we;

    aging_index_decode #(
        .IDX_W  (AGE_IDX_W),
        .WORD_W (AGE_WORD_W)
    ) u_decode (
        .valid    (hit_valid),
        .index    (hit_index),
        .word_sel (hit_word),
        .bit_mask (hit_mask)
    );

    for (genvar w = 0; w < AGE_WORDS; w++) begin : g_word
        logic [AGE_WORD_W-1:0] set_mask;
        logic                  wr_here;

        assign set_mask = (hit_word == AGE_ADDR_W'(w)) ? hit_mask : '0;
        assign wr_here  = wr_strobe && (bus_addr == AGE_ADDR_W'(w));

        aging_word_cell #(
            .WORD_W (AGE_WORD_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask),
            .wr_en    (wr_here),
            .wr_data  (bus_wdata),
            .q        (words[w])
        );
    end

    aging_read_port #(
        .NUM_WORDS (AGE_WORDS),
        .WORD_W    (AGE_WORD_W)
    ) u_read (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_strobe),
        .addr  (bus_addr),
        .words (words),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/aging_bitmap_checker.sv
module aging_bitmap_checker
    import aging_pkg::*;
(
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 hit_valid,
    input logic [AGE_IDX_W-1:0]                 hit_index,
    input logic                                 bus_req,
    input logic                                 bus_we,
    input logic [AGE_ADDR_W-1:0]                bus_addr,
    input logic [AGE_WORD_W-1:0]                bus_wdata,
    input logic [AGE_WORD_W-1:0]                bus_rdata,
    input logic [AGE_WORDS-1:0][AGE_WORD_W-1:0] words
);
    logic [AGE_ADDR_W-1:0] hw;
    logic [AGE_BIT_W-1:0]  hb;
    logic                  same_word_wr;

    assign hw = hit_index[AGE_IDX_W-1:AGE_BIT_W];
    assign hb = hit_index[AGE_BIT_W-1:0];
    assign same_word_wr = hit_valid && bus_req && bus_we && (bus_addr == hw);

    AST_HIT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> words[$past(hw)][$past(hb)] == 1'b1); // R2

    AST_WRITE_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !(hit_valid && bus_addr == hw)) |=> words[$past(bus_addr)] == $past(bus_wdata)); // R4

    AST_CONFLICT_KEEPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        same_word_wr |=> words[$past(bus_addr)][$past(hb)] == 1'b1); // R5

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rdata == $past(words[bus_addr])); // R7

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> $stable(bus_rdata)); // R7
endmodule

bind aging_bitmap aging_bitmap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_valid (hit_valid),
    .hit_index (hit_index),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .words     (words)
);

// File: tb/sim_aging_bitmap.sv
`timescale 1ns/1ps
module sim_aging_bitmap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic [12:0] hit_index = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [256];
    logic [31:0] last_rd;

    always #4 clk = ~clk;

    aging_bitmap u0 (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_index(hit_index),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] bit_of(input logic [12:0] idx);
        return 32'h1 << idx[4:0];
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit hv, input logic [12:0] hidx, input bit rq, input bit we,
                        input logic [7:0] ad, input logic [31:0] wd, input string req);
        @(negedge clk);
        hit_valid = hv; hit_index = hidx;
        bus_req = rq; bus_we = we; bus_addr = ad; bus_wdata = wd;
        @(posedge clk);
        #1;
        if (rq && !we) last_rd = model[ad];
        if (rq && we) model[ad] = wd;
        if (hv) model[hidx[12:5]] = model[hidx[12:5]] | bit_of(hidx);
        check(bus_rdata, last_rd, (rq && !we) ? req : {req, "/R7 hold"});
        @(negedge clk);
        hit_valid = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ad, input string req);
        step(1'b0, 13'h0, 1'b1, 1'b0, ad, 32'h0, req);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5A17);
        for (int i = 0; i < 256; i++) model[i] = '0;
        last_rd = '0;
        repeat (3) @(posedge clk);
        #1;
        check(bus_rdata, 32'h0, "R1 rdata reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) rd(8'(i), "R1 cleared word");

        // R2 / R3: hit entry 0x1234 -> word 0x91, bit 20
        step(1'b1, 13'h1234, 1'b0, 1'b0, 8'h0, 32'h0, "R2");
        rd(8'h91, "R2 bit set");
        rd(8'h90, "R3 neighbour word untouched");
        step(1'b1, 13'h1234, 1'b0, 1'b0, 8'h0, 32'h0, "R3");
        rd(8'h91, "R3 sticky");
        // R8: strobe low
        step(1'b0, 13'h1FFF, 1'b0, 1'b0, 8'h0, 32'h0, "R8");
        rd(8'hFF, "R8 index ignored");
        // R4
        step(1'b0, 13'h0, 1'b1, 1'b1, 8'h91, 32'hA5A5_0F0F, "R4");
        rd(8'h91, "R4 word replaced");
        // R5: clear word 3 while hitting bit 7 of it
        step(1'b1, 13'h0067, 1'b1, 1'b1, 8'h03, 32'h0, "R5");
        rd(8'h03, "R5 hit survives clear");
        // R6
        step(1'b1, 13'h00A1, 1'b1, 1'b1, 8'h04, 32'h1111_0000, "R6");
        rd(8'h04, "R6 write word");
        rd(8'h05, "R6 hit word");
        // R9: read and hit word 0x10 together
        step(1'b1, 13'h0209, 1'b1, 1'b0, 8'h10, 32'h0, "R9 pre-hit value");
        rd(8'h10, "R9 bit after");

        for (int n = 0; n < 3000; n++) begin
            logic [12:0] idx;
            logic [7:0]  ad;
            logic [1:0]  op;
            idx = {5'($urandom_range(3, 0)) + 5'd8, 3'b0, 5'($urandom)};
            idx[12:5] = 8'($urandom_range(67, 64));
            ad = 8'($urandom_range(67, 64));
            op = 2'($urandom);
            step(1'($urandom), idx, op != 2'd0, op == 2'd3, ad,
                 ($urandom_range(1, 0) == 0) ? 32'h0 : $urandom, "R3/R5/R6/R7 random");
        end
        for (int i = 64; i < 68; i++) rd(8'(i), "R3 final sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule